// File: doc/BRIEF.md
# Pipelined Priority Bus Arbiter

This block shares one high-bandwidth local bus among several masters. Each master raises a request together with a two-bit urgency level, a bus address and a byte of transfer attributes. The arbiter picks one requester, drives a registered one-hot grant back to it, and forwards the chosen master's address and attributes to the slave side for as long as that address phase lasts. A slave closes the address phase with an acknowledge, and later closes the matching data phase with a completion pulse.

The arbiter does not wait for the bus to drain. While one transfer is still moving data, the next requester can be chosen and its address accepted. At most two accepted transfers may be waiting on data at any time: one in its data phase and one pipelined behind it. A master that asserts its lock input when its address is acknowledged keeps the bus until it drops that input. An address phase that no slave acknowledges is cut off after a fixed number of cycles, and the owning master receives a one-cycle error pulse.

Top module: `pbus_arbiter`

## Requirements
- R1: Among requesting masters, the arbiter grants the master whose 2-bit level (master i uses bits [2i+1:2i] of `m_pri`, 3 highest, 0 lowest) is greatest.
- R2: When several requesters share the greatest level, the arbiter grants the first one found when counting upward from the master granted last, wrapping around. After reset, master 0 counts first.
- R3: `m_gnt` is one-hot or zero. It rises on the clock edge after a request is seen while the bus is free, and it stays unchanged until the edge at which `s_addr_ack` is sampled high or the timeout fires.
- R4: While a grant is active, `s_valid` is 1, and `s_addr`, `s_qual` and `s_mid` carry the granted master's address, attributes and index. When no grant is active, `s_valid` is 0.
- R5: When two acknowledged transfers are still waiting for `s_data_done`, no new grant is issued. The edge that samples `s_data_done` retires the oldest one, and a waiting request is granted on the following edge.
- R6: A new grant can be issued while one acknowledged transfer is still waiting for `s_data_done`.
- R7: If a master's lock bit (`m_lock[i]`) is high when its address is acknowledged, only that master can be granted from then on. This holds even if other masters have higher levels. It ends on the edge that samples the owner's lock bit low.
- R8: If a grant sees no `s_addr_ack` during 16 consecutive cycles, the grant drops after the 16th cycle. On the same edge, `m_err` pulses for one cycle on the bit of that master, and the transfer is not counted as waiting for data.
- R9: During and right after reset, `m_gnt`, `m_err` and `s_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NM | Request bit per master |
| m_pri | input | 2*NM | Two-bit level per master |
| m_lock | input | NM | Lock request per master |
| m_addr | input | NM*AW | Address per master |
| m_qual | input | NM*QW | Transfer attributes per master |
| m_gnt | output | NM | Registered one-hot grant |
| m_err | output | NM | One-cycle timeout error per master |
| s_valid | output | 1 | Address phase active toward slaves |
| s_addr | output | AW | Forwarded address |
| s_qual | output | QW | Forwarded attributes |
| s_mid | output | $clog2(NM) | Index of the granted master |
| s_addr_ack | input | 1 | Slave accepts the current address |
| s_data_done | input | 1 | Oldest outstanding data phase finished |

## Verification
The hardest state to reach is a full pipeline with a request waiting behind it. This needs two acknowledged addresses with no completion between them, plus a third requester held off, and it must happen before the bench releases a single completion. The stimulus builds this directly. It acknowledges two grants back to back while holding `s_data_done` low, watches the third request stay ungranted for several cycles, and then times one completion pulse to check the grant on the following edge. The lock sequence is reached the same way. Completions are spaced so that the owner's lock is still held while a higher-level master competes for the bus.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef logic [1:0] lvl_t;

  // position reached when stepping from base by step around a ring of n
  function automatic int unsigned ring_next(int unsigned base, int unsigned step,
                                            int unsigned n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int unsigned NM = 4,
  parameter int unsigned IW = 2
) (
  input  logic [NM-1:0]   cand,
  input  logic [2*NM-1:0] lvl,
  input  logic [IW-1:0]   last,
  output logic            win_vld,
  output logic [IW-1:0]   win_id
);
  import arb_pkg::*;

  lvl_t top_lvl;

  always_comb begin
    top_lvl = '0;
    for (int unsigned i = 0; i < NM; i++) begin
      if (cand[i] && lvl[2*i +: 2] > top_lvl) top_lvl = lvl[2*i +: 2];
    end
  end

  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    for (int unsigned d = 1; d <= NM; d++) begin
      int unsigned k;
      k = ring_next(int'(last), d, NM);
      if (!win_vld && cand[k] && lvl[2*k +: 2] == top_lvl) begin
        win_vld = 1'b1;
        win_id  = IW'(k);
      end
    end
  end
endmodule

// File: rtl/arb_tenure.sv
module arb_tenure #(
  parameter int unsigned NM = 4,
  parameter int unsigned IW = 2,
  parameter int unsigned TO = 16,
  localparam int unsigned TW = (TO > 2) ? $clog2(TO) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_vld,
  input  logic [IW-1:0] win_id,
  input  logic          addr_ack,
  input  logic          data_done,
  input  logic [NM-1:0] lock_in,
  output logic [NM-1:0] gnt,
  output logic [IW-1:0] gnt_id,
  output logic [IW-1:0] last_id,
  output logic          lock_hold,
  output logic [IW-1:0] lock_id,
  output logic [1:0]    pend,
  output logic          grant_fire,
  output logic          ack_fire,
  output logic          tmo_fire,
  output logic [NM-1:0] err
);
  logic          busy;
  logic          may_grant;
  logic          retire;
  logic [TW-1:0] timer;

  assign busy       = |gnt;
  assign may_grant  = !busy && (pend != 2'd2);
  assign grant_fire = may_grant && win_vld;
  assign ack_fire   = busy && addr_ack;
  assign tmo_fire   = busy && !addr_ack && (timer == TW'(TO - 1));
  assign retire     = data_done && (pend != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt     <= '0;
      gnt_id  <= '0;
      last_id <= IW'(NM - 1);
    end else if (grant_fire) begin
      gnt     <= {{(NM-1){1'b0}}, 1'b1} << win_id;
      gnt_id  <= win_id;
      last_id <= win_id;
    end else if (ack_fire || tmo_fire) begin
      gnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || ack_fire || tmo_fire) timer <= '0;
    else                                         timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else begin
      case ({ack_fire, retire})
        2'b10:   pend <= pend + 2'd1;
        2'b01:   pend <= pend - 2'd1;
        default: pend <= pend;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_hold <= 1'b0;
      lock_id   <= '0;
    end else if (ack_fire && lock_in[gnt_id]) begin
      lock_hold <= 1'b1;
      lock_id   <= gnt_id;
    end else if (lock_hold && !lock_in[lock_id]) begin
      lock_hold <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        err <= '0;
    else if (tmo_fire) err <= gnt;
    else               err <= '0;
  end
endmodule

// File: rtl/pbus_arbiter.sv
module pbus_arbiter #(
  parameter int unsigned NM = 4,
  parameter int unsigned AW = 32,
  parameter int unsigned QW = 8,
  parameter int unsigned TO = 16,
  localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NM-1:0]   m_req,
  input  logic [2*NM-1:0] m_pri,
  input  logic [NM-1:0]   m_lock,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM*QW-1:0] m_qual,
  output logic [NM-1:0]   m_gnt,
  output logic [NM-1:0]   m_err,
  output logic            s_valid,
  output logic [AW-1:0]   s_addr,
  output logic [QW-1:0]   s_qual,
  output logic [IW-1:0]   s_mid,
  input  logic            s_addr_ack,
  input  logic            s_data_done
);
  logic [NM-1:0] cand;
  logic [NM-1:0] own_mask;
  logic          win_vld;
  logic [IW-1:0] win_id;
  logic [IW-1:0] gnt_id;
  logic [IW-1:0] last_id;
  logic          lock_hold;
  logic [IW-1:0] lock_id;
  logic [1:0]    pend;
  logic          grant_fire;
  logic          ack_fire;
  logic          tmo_fire;
  logic [AW-1:0] addr_term [NM];
  logic [QW-1:0] qual_term [NM];

  assign own_mask = {{(NM-1){1'b0}}, 1'b1} << lock_id;
  assign cand     = lock_hold ? (m_req & own_mask) : m_req;

  arb_pick #(.NM(NM), .IW(IW)) u_pick (
    .cand(cand), .lvl(m_pri), .last(last_id),
    .win_vld(win_vld), .win_id(win_id)
  );

  arb_tenure #(.NM(NM), .IW(IW), .TO(TO)) u_ten (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_id(win_id),
    .addr_ack(s_addr_ack), .data_done(s_data_done), .lock_in(m_lock),
    .gnt(m_gnt), .gnt_id(gnt_id), .last_id(last_id),
    .lock_hold(lock_hold), .lock_id(lock_id), .pend(pend),
    .grant_fire(grant_fire), .ack_fire(ack_fire), .tmo_fire(tmo_fire),
    .err(m_err)
  );

  for (genvar g = 0; g < NM; g++) begin : g_term
    assign addr_term[g] = m_gnt[g] ? m_addr[g*AW +: AW] : '0;
    assign qual_term[g] = m_gnt[g] ? m_qual[g*QW +: QW] : '0;
  end

  always_comb begin
    s_addr = '0;
    s_qual = '0;
    for (int unsigned i = 0; i < NM; i++) begin
      s_addr = s_addr | addr_term[i];
      s_qual = s_qual | qual_term[i];
    end
  end

  assign s_valid = |m_gnt;
  assign s_mid   = gnt_id;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int unsigned NM = 4,
  parameter int unsigned IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] m_gnt,
  input logic [NM-1:0] m_err,
  input logic          s_valid,
  input logic [IW-1:0] s_mid,
  input logic          s_addr_ack,
  input logic          tmo_fire,
  input logic          lock_hold,
  input logic [IW-1:0] lock_id,
  input logic [1:0]    pend
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_gnt));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_gnt != '0 && !s_addr_ack && !tmo_fire) |=> $stable(m_gnt));

  p_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> m_gnt[s_mid]);

  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == 2'd2 && m_gnt == '0) |=> m_gnt == '0);

  p_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hold && m_gnt == '0) |=>
      (m_gnt == '0 || m_gnt == ({{(NM-1){1'b0}}, 1'b1} << $past(lock_id))));

  p_errsrc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_err != '0) |-> ($past(m_gnt) == m_err && !$past(s_addr_ack)));

  p_errpulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_err != '0) |=> m_err == '0);
endmodule

bind pbus_arbiter arb_chk #(.NM(NM), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_gnt(m_gnt), .m_err(m_err),
  .s_valid(s_valid), .s_mid(s_mid), .s_addr_ack(s_addr_ack),
  .tmo_fire(tmo_fire), .lock_hold(lock_hold), .lock_id(lock_id), .pend(pend)
);

// File: tb/sim_pbus_arbiter.sv
`timescale 1ns/1ps
module sim_pbus_arbiter;
  localparam int NM = 4;
  localparam int AW = 32;
  localparam int QW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NM-1:0]   m_req = '0;
  logic [2*NM-1:0] m_pri = '0;
  logic [NM-1:0]   m_lock = '0;
  logic [NM*AW-1:0] m_addr;
  logic [NM*QW-1:0] m_qual;
  logic [NM-1:0]   m_gnt;
  logic [NM-1:0]   m_err;
  logic            s_valid;
  logic [AW-1:0]   s_addr;
  logic [QW-1:0]   s_qual;
  logic [1:0]      s_mid;
  logic            s_addr_ack = 1'b0;
  logic            s_data_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int blast = NM - 1;

  always #2 clk = ~clk;

  pbus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_pri(m_pri), .m_lock(m_lock),
    .m_addr(m_addr), .m_qual(m_qual), .m_gnt(m_gnt), .m_err(m_err),
    .s_valid(s_valid), .s_addr(s_addr), .s_qual(s_qual), .s_mid(s_mid),
    .s_addr_ack(s_addr_ack), .s_data_done(s_data_done)
  );

  function automatic logic [AW-1:0] addr_of(int m);
    return AW'(32'h1000_0000 * (m + 1) + m * 4);
  endfunction

  // expected winner: scan the ring after the last grant, keep strictly higher levels
  function automatic int ref_win(logic [NM-1:0] r, logic [2*NM-1:0] p, int last);
    int best = -1;
    int bl = -1;
    for (int d = 1; d <= NM; d++) begin
      int i = (last + d) % NM;
      if (r[i] && int'(p[2*i +: 2]) > bl) begin
        bl = int'(p[2*i +: 2]);
        best = i;
      end
    end
    return best;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // acknowledge current grant, then retire it in the next cycle
  task automatic ack_retire(input logic [NM-1:0] keep_req);
    s_addr_ack = 1'b1; m_req = keep_req; tick();
    s_addr_ack = 1'b0; s_data_done = 1'b1; tick();
    s_data_done = 1'b0;
  endtask

  task automatic done_pulse();
    s_data_done = 1'b1; tick();
    s_data_done = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int e;
    void'($urandom(1234));
    for (int i = 0; i < NM; i++) begin
      m_addr[i*AW +: AW] = addr_of(i);
      m_qual[i*QW +: QW] = QW'(8'h30 + i);
    end
    tick(); tick();
    chk(m_gnt == 0 && m_err == 0 && !s_valid, "R9 in reset", {m_gnt, m_err}, 0);
    rst_n = 1'b1;
    tick();
    chk(m_gnt == 0 && m_err == 0 && !s_valid, "R9 after reset", {m_gnt, m_err}, 0);

    // random rounds: level and ring order against the bench model
    for (int r = 0; r < 40; r++) begin
      m_req = NM'($urandom % 15 + 1);
      m_pri = 8'($urandom);
      e = ref_win(m_req, m_pri, blast);
      tick();
      chk(m_gnt == (4'b1 << e), "R2 random winner", m_gnt, 4'b1 << e);
      chk(s_valid && s_addr == addr_of(e) && s_qual == QW'(8'h30 + e) && s_mid == 2'(e),
          "R4 random route", s_addr, addr_of(e));
      blast = e;
      ack_retire('0);
    end

    // R1: unique top level wins
    m_req = 4'b1111; m_pri = 8'b10_01_11_00;
    tick();
    chk(m_gnt == 4'b0010, "R1 top level", m_gnt, 4'b0010);
    ack_retire('0);

    // R2: equal levels rotate after master 1
    m_req = 4'b1111; m_pri = 8'b01_01_01_01;
    tick();
    chk(m_gnt == 4'b0100, "R2 rotate a", m_gnt, 4'b0100);
    ack_retire(4'b1111);
    chk(m_gnt == 4'b1000, "R2 rotate b", m_gnt, 4'b1000);
    ack_retire(4'b1111);
    chk(m_gnt == 4'b0001, "R2 wrap", m_gnt, 4'b0001);

    // R3: grant holds without acknowledge
    m_req = 4'b0000;
    tick(); tick(); tick();
    chk(m_gnt == 4'b0001, "R3 stable", m_gnt, 4'b0001);
    chk(s_addr == addr_of(0) && s_mid == 2'd0, "R4 route held", s_addr, addr_of(0));
    ack_retire('0);
    chk(m_gnt == 0 && !s_valid, "R4 idle", s_valid, 0);

    // R6 / R5: pipeline depth
    m_pri = '0; m_req = 4'b0001;
    tick();
    chk(m_gnt == 4'b0001, "R6 first", m_gnt, 4'b0001);
    s_addr_ack = 1'b1; m_req = 0; tick(); s_addr_ack = 1'b0;
    m_req = 4'b0010;
    tick();
    chk(m_gnt == 4'b0010, "R6 overlap grant", m_gnt, 4'b0010);
    s_addr_ack = 1'b1; m_req = 0; tick(); s_addr_ack = 1'b0;
    m_req = 4'b0100;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(m_gnt == 0, "R5 held off", m_gnt, 0);
    end
    done_pulse();
    chk(m_gnt == 0, "R5 edge of retire", m_gnt, 0);
    tick();
    chk(m_gnt == 4'b0100, "R5 granted after retire", m_gnt, 4'b0100);
    s_addr_ack = 1'b1; m_req = 0; tick(); s_addr_ack = 1'b0;
    done_pulse(); done_pulse(); done_pulse();

    // R7: lock ownership
    m_req = 4'b0100; m_lock = 4'b0100;
    tick();
    chk(m_gnt == 4'b0100, "R7 owner first", m_gnt, 4'b0100);
    s_addr_ack = 1'b1; m_req = 0; tick(); s_addr_ack = 1'b0;
    m_req = 4'b1000; m_pri = 8'b11_00_00_00;
    done_pulse();
    tick();
    chk(m_gnt == 0, "R7 others blocked", m_gnt, 0);
    m_req = 4'b1100;
    tick();
    chk(m_gnt == 4'b0100, "R7 owner over higher level", m_gnt, 4'b0100);
    s_addr_ack = 1'b1; m_req = 4'b1000; m_lock = 0; tick(); s_addr_ack = 1'b0;
    chk(m_gnt == 0, "R7 release edge", m_gnt, 0);
    tick();
    chk(m_gnt == 4'b1000, "R7 released", m_gnt, 4'b1000);
    s_addr_ack = 1'b1; m_req = 0; tick(); s_addr_ack = 1'b0;
    done_pulse(); done_pulse();

    // R8: address timeout
    m_pri = '0; m_req = 4'b1000;
    tick();
    m_req = 0;
    n = 0;
    while (m_gnt != 0 && n < 40) begin
      n++;
      tick();
    end
    chk(n == 16, "R8 grant length", n, 16);
    chk(m_err == 4'b1000, "R8 error pulse", m_err, 4'b1000);
    tick();
    chk(m_err == 0, "R8 pulse ends", m_err, 0);
    // R8: timed-out tenure not counted, so two more grants pass with no retire
    m_req = 4'b0001; tick();
    chk(m_gnt == 4'b0001, "R8 not counted a", m_gnt, 4'b0001);
    s_addr_ack = 1'b1; m_req = 0; tick(); s_addr_ack = 1'b0;
    m_req = 4'b0010; tick();
    chk(m_gnt == 4'b0010, "R8 not counted b", m_gnt, 4'b0010);
    s_addr_ack = 1'b1; m_req = 0; tick(); s_addr_ack = 1'b0;
    done_pulse(); done_pulse();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule